// File: doc/BRIEF.md
# Serial Byte-Memory Slave Engine

This block is the slave side of a four-wire serial bus in front of a 512-byte memory. The memory is modelled as a synchronous RAM. Chip select, serial clock, serial input and a hold line come from outside the system clock domain. The block re-times them with two flops each and works on edges it finds in the re-timed copies.

Each select period carries one command byte. The command picks one of six actions:
- set the write-enable flag;
- clear the write-enable flag;
- read the status byte;
- write the status byte;
- read memory;
- write memory.

Memory commands put the top address bit inside the command byte. One more byte then gives the low eight address bits. Data bytes then stream for as long as select stays low, and the address steps once per byte.

Writes finish at bus speed, so the block has no busy flag. An external protection unit grants or refuses writes through the `wr_permit` input. The serial output comes as a data bit plus an enable, which the pad ring uses to build the tri-state driver.

Top module: `spi_mem_slave`

## Requirements
- R1: Command bytes arrive MSB first and are sampled on rising serial-clock edges. The codes are:
  - 0x06: set write enable.
  - 0x04: clear write enable.
  - 0x05: status read.
  - 0x01: status write.
  - 0000_A011: memory read.
  - 0000_A010: memory write.

  A is address bit 8. The next byte holds address bits 7..0.
- R2: During a memory read, each byte comes out MSB first. Each bit changes after a falling serial-clock edge, and the first bit appears on the falling edge that follows the last address bit. `so_oe` is high only in the data phase of a memory or status read.
- R3: A memory write byte is stored only when three conditions all hold:
  - all eight of its bits were received;
  - the write-enable flag was set;
  - `wr_permit` was high.

  A partial last byte is dropped.
- R4: The set and clear commands control the write-enable flag, which reads back as status bit 1. The flag also clears when a select period that carried a memory write or status write command ends.
- R5: The status byte reads as {S7,0,0,0,S3,S2,WEL,0}, and every bit is 0 after reset. A status write updates only S7, S3 and S2, and only under the same permission as a memory write.
- R6: While chip select is high, the serial clock and serial input have no effect, and `so_oe` is low.
- R7: While `hold_n` is low, the block ignores serial-clock and chip-select edges, keeps its bit position and address, and holds `so_oe` low. The transfer resumes at the same bit once `hold_n` returns high.
- R8: In memory reads and writes the address steps by one after each byte and wraps from 0x1FF to 0x000.
- R9: Only the first byte of a select period is decoded as a command. After an unknown command the rest of the period is ignored and `so_oe` stays low.
- R10: Both bus modes 0 and 3 work, that is, with the serial clock idling low or idling high.
- R11: A read that starts right after a write select period returns the new data, with no polling in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low suspend |
| wr_permit | input | 1 | External grant for any write |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |

## Verification
Two functions can fall in the same cycle and are checked together.

The first pair is address stepping and the end of a byte. The last rising edge of a data byte both commits the byte, or requests the next read byte, and advances the address. The bench provokes this with bursts that start at 0x1FE, so the step crosses the wrap, and with a read that follows a write directly.

The second pair is a hold that begins with a shift edge pending. The bench lowers hold in the middle of a read byte and toggles the clock while hold is low. It then judges that `so_oe` dropped and that the remaining bits resume with no skipped or repeated bit.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W = 9,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic hold_n,
  input  logic wr_permit,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {
    P_OP = 3'd0, P_ADR = 3'd1, P_RD = 3'd2, P_WR = 3'd3,
    P_SRD = 3'd4, P_SWR = 3'd5, P_DONE = 3'd6
  } phase_t;

  logic [SYNC_N-1:0] cs_sy, sck_sy, si_sy, hold_sy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy   <= '1;
      sck_sy  <= '0;
      si_sy   <= '0;
      hold_sy <= '1;
    end else begin
      cs_sy   <= {cs_sy[SYNC_N-2:0], cs_n};
      sck_sy  <= {sck_sy[SYNC_N-2:0], sck};
      si_sy   <= {si_sy[SYNC_N-2:0], si};
      hold_sy <= {hold_sy[SYNC_N-2:0], hold_n};
    end

  wire cs_s    = cs_sy[SYNC_N-1];
  wire sck_s   = sck_sy[SYNC_N-1];
  wire si_s    = si_sy[SYNC_N-1];
  wire hold_on = hold_sy[SYNC_N-1];

  logic cs_eff, sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_eff <= 1'b1;
      sck_d  <= 1'b0;
    end else if (hold_on) begin
      cs_eff <= cs_s;
      sck_d  <= sck_s;
    end

  wire cs_sel   = ~cs_eff;
  wire cs_start = hold_on & cs_eff & ~cs_s;
  wire cs_end   = hold_on & ~cs_eff & cs_s;
  wire rise     = hold_on & cs_sel & sck_s & ~sck_d;
  wire fall     = hold_on & cs_sel & ~sck_s & sck_d;

  phase_t            phase;
  logic [2:0]        bitcnt;
  logic [7:0]        rx, tx, rd_q;
  logic [ADDR_W-1:0] addr;
  logic              is_rd, wr_op, wel, load_pend, rd_live, so_q, oe_q;
  logic [2:0]        st;
  logic [7:0]        mem [DEPTH];

  wire [7:0] rx_nxt    = {rx[6:0], si_s};
  wire       byte_done = rise & (bitcnt == 3'd7);
  wire       mem_we    = byte_done & (phase == P_WR) & wel & wr_permit;
  wire [7:0] status    = {st[2], 3'b000, st[1:0], wel, 1'b0};
  wire [7:0] src       = (phase == P_SRD) ? status : rd_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase     <= P_DONE;
      bitcnt    <= '0;
      rx        <= '0;
      tx        <= '0;
      addr      <= '0;
      is_rd     <= 1'b0;
      wr_op     <= 1'b0;
      wel       <= 1'b0;
      st        <= '0;
      load_pend <= 1'b0;
      rd_live   <= 1'b0;
      so_q      <= 1'b0;
    end else begin
      if (cs_start) begin
        phase     <= P_OP;
        bitcnt    <= '0;
        wr_op     <= 1'b0;
        load_pend <= 1'b0;
        rd_live   <= 1'b0;
      end
      if (cs_end) begin
        phase     <= P_DONE;
        load_pend <= 1'b0;
        rd_live   <= 1'b0;
        if (wr_op) wel <= 1'b0;
      end
      if (rise) begin
        rx     <= rx_nxt;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          case (phase)
            P_OP: begin
              if (rx_nxt == 8'h06) begin
                wel   <= 1'b1;
                phase <= P_DONE;
              end else if (rx_nxt == 8'h04) begin
                wel   <= 1'b0;
                phase <= P_DONE;
              end else if (rx_nxt == 8'h05) begin
                phase     <= P_SRD;
                load_pend <= 1'b1;
              end else if (rx_nxt == 8'h01) begin
                phase <= P_SWR;
                wr_op <= 1'b1;
              end else if (rx_nxt[7:4] == 4'h0 && rx_nxt[2:1] == 2'b01) begin
                addr[ADDR_W-1] <= rx_nxt[3];
                is_rd          <= rx_nxt[0];
                wr_op          <= ~rx_nxt[0];
                phase          <= P_ADR;
              end else begin
                phase <= P_DONE;
              end
            end
            P_ADR: begin
              addr[7:0] <= rx_nxt;
              phase     <= is_rd ? P_RD : P_WR;
              load_pend <= is_rd;
            end
            P_RD: begin
              addr      <= addr + 1'b1;
              load_pend <= 1'b1;
            end
            P_WR:  addr <= addr + 1'b1;
            P_SRD: load_pend <= 1'b1;
            P_SWR: begin
              if (wel && wr_permit) st <= {rx_nxt[7], rx_nxt[3:2]};
              phase <= P_DONE;
            end
            default: ;
          endcase
        end
      end
      if (fall) begin
        if (load_pend) begin
          so_q      <= src[7];
          tx        <= {src[6:0], 1'b0};
          load_pend <= 1'b0;
          rd_live   <= 1'b1;
        end else begin
          so_q <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= hold_on & cs_sel & rd_live & ((phase == P_RD) | (phase == P_SRD));

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= rx_nxt;
    rd_q <= mem[addr];
  end

  assign so    = so_q;
  assign so_oe = oe_q;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold_on,
  input logic              cs_sel,
  input logic              cs_end,
  input logic              wr_op,
  input logic              wel,
  input logic              so_oe,
  input logic [2:0]        bitcnt,
  input logic [2:0]        phase,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [2:0] PH_RD = 3'd2;
  localparam logic [2:0] PH_WR = 3'd3;

  a_r7_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_on |=> ($stable(bitcnt) && $stable(addr)));

  a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_on |=> !so_oe);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sel |=> !so_oe);

  a_r4_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_end && wr_op) |=> !wel);

  a_r8_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_RD || phase == PH_WR) && $past(phase) == phase && addr != $past(addr))
      |-> addr == $past(addr) + 1'b1);
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_on(hold_on), .cs_sel(cs_sel), .cs_end(cs_end),
  .wr_op(wr_op), .wel(wel), .so_oe(so_oe), .bitcnt(bitcnt), .phase(phase), .addr(addr)
);

// File: tb/tb_spi_mem_slave.sv
module tb_spi_mem_slave;
  localparam int HALF = 160;

  logic clk = 1'b0;
  logic rst_n, cs_n, sck, si, hold_n, wr_permit;
  logic so, so_oe;

  always #10 clk = ~clk;

  spi_mem_slave dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_n(hold_n), .wr_permit(wr_permit), .so(so), .so_oe(so_oe)
  );

  int total = 0;
  int bad = 0;
  bit mode3 = 1'b0;
  bit oe_seen;
  logic [7:0] last_rx;
  logic [7:0] model [512];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic begin_sel();
    sck = mode3;
    #HALF;
    cs_n = 1'b0;
    oe_seen = 1'b0;
    #HALF;
  endtask

  task automatic end_sel();
    if (!mode3) begin
      sck = 1'b0;
      #HALF;
    end
    cs_n = 1'b1;
    #(2*HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nbits, input int hold_at);
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b0;
      si = tx[7-i];
      if (i == hold_at) begin
        #HALF;
        hold_n = 1'b0;
        #HALF;
        for (int k = 0; k < 3; k++) begin
          sck = 1'b1; si = ~si; #HALF;
          chk(so_oe == 1'b0, "R7", "so_oe during hold", so_oe, 0);
          sck = 1'b0; #HALF;
        end
        si = tx[7-i];
        hold_n = 1'b1;
      end
      #HALF;
      last_rx[7-i] = so;
      if (so_oe) oe_seen = 1'b1;
      sck = 1'b1;
      #HALF;
    end
  endtask

  task automatic cmd(input logic [7:0] op);
    begin_sel(); xfer(op, 8, 99); end_sel();
  endtask

  task automatic rdsr(output logic [7:0] v);
    begin_sel(); xfer(8'h05, 8, 99); xfer(8'h00, 8, 99); v = last_rx; end_sel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    begin_sel(); xfer(8'h01, 8, 99); xfer(v, 8, 99); end_sel();
  endtask

  task automatic mem_write(input int a, input int n, input logic [7:0] v0, input bit commit);
    begin_sel();
    xfer({4'h0, a[8], 3'b010}, 8, 99);
    xfer(a[7:0], 8, 99);
    for (int i = 0; i < n; i++) begin
      xfer(v0 + 8'(i), 8, 99);
      if (commit) model[(a + i) % 512] = v0 + 8'(i);
    end
    chk(oe_seen == 1'b0, "R2", "so_oe during write", oe_seen, 0);
    end_sel();
  endtask

  task automatic mem_read(input int a, input int n, input string req, input int hold_byte);
    begin_sel();
    xfer({4'h0, a[8], 3'b011}, 8, 99);
    xfer(a[7:0], 8, 99);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, (i == hold_byte) ? 3 : 99);
      chk(last_rx === model[(a + i) % 512], req, $sformatf("read byte @%0h", (a + i) % 512),
          last_rx, model[(a + i) % 512]);
    end
    chk(oe_seen == 1'b1, "R2", "so_oe in read", oe_seen, 1);
    end_sel();
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk(so_oe == 1'b0, "R6", "so_oe after reset", so_oe, 0);
    rdsr(s);
    chk(s == 8'h00, "R5", "status after reset", s, 0);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd(8'h06); rdsr(s);
    chk(s == 8'h02, "R4", "status after set-enable", s, 8'h02);
    cmd(8'h04); rdsr(s);
    chk(s == 8'h00, "R4", "status after clear-enable", s, 0);
  endtask

  task automatic t_write_wrap();
    logic [7:0] s;
    cmd(8'h06); mem_write(9'h1FE, 4, 8'hA0, 1'b1);
    mem_read(9'h1FE, 4, "R8", 99);
    rdsr(s);
    chk(s == 8'h00, "R4", "enable cleared after write", s, 0);
    cmd(8'h06); mem_write(9'h0FE, 1, 8'h5A, 1'b1);
    mem_read(9'h1FE, 1, "R1", 99);
    mem_read(9'h0FE, 1, "R11", 99);
  endtask

  task automatic t_no_permit();
    mem_write(9'h1FE, 1, 8'h77, 1'b0);
    mem_read(9'h1FE, 1, "R3", 99);
    wr_permit = 1'b0;
    cmd(8'h06); mem_write(9'h000, 1, 8'h99, 1'b0);
    wr_permit = 1'b1;
    mem_read(9'h000, 1, "R3", 99);
    cmd(8'h04);
  endtask

  task automatic t_partial();
    cmd(8'h06); mem_write(9'h020, 2, 8'h30, 1'b1);
    cmd(8'h06);
    begin_sel();
    xfer(8'h02, 8, 99); xfer(8'h20, 8, 99);
    xfer(8'hC1, 8, 99); model[9'h020] = 8'hC1;
    xfer(8'hEE, 4, 99);
    end_sel();
    mem_read(9'h020, 2, "R3", 99);
  endtask

  task automatic t_status();
    logic [7:0] s;
    cmd(8'h06); wrsr(8'hFF); rdsr(s);
    chk(s == 8'h8C, "R5", "status write masked", s, 8'h8C);
    wrsr(8'h00); rdsr(s);
    chk(s == 8'h8C, "R5", "status write without enable", s, 8'h8C);
    cmd(8'h06); wrsr(8'h00); rdsr(s);
    chk(s == 8'h00, "R5", "status cleared", s, 0);
  endtask

  task automatic t_one_op();
    logic [7:0] s;
    begin_sel(); xfer(8'h06, 8, 99); xfer(8'h04, 8, 99); end_sel();
    rdsr(s);
    chk(s == 8'h02, "R9", "second command ignored", s, 8'h02);
    cmd(8'h04);
    begin_sel(); xfer(8'h87, 8, 99); xfer(8'h05, 8, 99); xfer(8'h03, 8, 99); end_sel();
    chk(oe_seen == 1'b0, "R9", "so_oe after unknown command", oe_seen, 0);
  endtask

  task automatic t_mode3();
    mode3 = 1'b1;
    cmd(8'h06); mem_write(9'h1FF, 2, 8'h61, 1'b1);
    mem_read(9'h1FE, 3, "R10", 99);
    mode3 = 1'b0;
  endtask

  task automatic t_hold();
    mem_read(9'h1FE, 3, "R7", 1);
  endtask

  task automatic t_idle();
    logic [7:0] s;
    for (int i = 0; i < 20; i++) begin
      sck = ~sck; si = ~si; #HALF;
      if (so_oe) oe_seen = 1'b1;
    end
    sck = 1'b0;
    chk(so_oe == 1'b0, "R6", "so_oe while deselected", so_oe, 0);
    rdsr(s);
    chk(s == 8'h00, "R6", "status after idle toggling", s, 0);
  endtask

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; wr_permit = 1'b1;
    #105 rst_n = 1'b1;
    #100;
    t_reset();
    t_wel();
    t_write_wrap();
    t_no_permit();
    t_partial();
    t_status();
    t_one_op();
    t_mode3();
    t_hold();
    t_idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule